// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that sits on a simple word-wide register bus. The bus has an address, a write strobe, write data and a combinational read-data return. A strobe arriving once every half second drives an 8-bit down-counter. Software arms the watchdog by setting the enable bit in the mode register, which loads a timeout chosen from a fixed, non-linear table of half-second multiples. Software then keeps the system alive by writing a restart command to the control register. In the default layout, that command is honoured only when it carries a 12-bit key.

When the count runs out, the counter stops at zero. The block then emits a one-cycle system-reset request, but only if the enable bit and the reset-enable bit are both set at that moment. A build parameter selects a second, keyless layout. That layout has only two registers, accepts restarts without a key, and places the reset enable and the interval code in the mode register. The remaining registers of the keyed layout are plain storage, kept for software that expects them.

Top module: `wdog_keyed`

## Requirements
- R1: After reset every mapped register reads 0, the counter is idle and `sys_rst_req` is low.
- R2: Keyed layout offsets are: 0x10 restart/control, 0x14 configuration, 0x18 mode, 0x00 and 0x04 two storage words. Reads of any other offset return 0, and writes to them change nothing.
- R3: The two storage words and the configuration word hold and return all 32 written bits.
- R4: A control write restarts the count only if bit 0 is 1 and bits 12:1 equal 0xA57 (keyed layout). Any other control write has no effect. The control register always reads 0.
- R5: The mode register holds the enable in bit 0 and the interval code in bits 7:4 (keyed). Codes 0..11 load 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 ticks respectively.
- R6: A mode write reloads and restarts the counter only when it moves bit 0 from 0 to 1. Rewriting the register while it is enabled leaves the count running untouched.
- R7: On a reload with an illegal code (12..15), the counter keeps its current count and is still restarted.
- R8: Each tick lowers a running count by one. On the tick that takes it to zero the counter stops, and further ticks have no effect until the next restart or enable edge. A reload in the same cycle as a tick takes precedence.
- R9: `sys_rst_req` is high for exactly the one cycle after the expiring tick. It is raised only when the enable bit and the reset-enable bit (configuration bit 0 in the keyed layout) are both set.
- R10: With `KEYED=0`, control sits at 0x00 and mode at 0x04, with no key check. Reset-enable is mode bit 1, the interval code is mode bits 6:3, and all other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe, once per half second |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count or a stuck running flag shows up only at expiry. A reset pulse then arrives one or more ticks early or late, appears twice, or fails to appear. The bench therefore compares `sys_rst_req` against a behavioural model on every cycle, and the first misplaced pulse is caught within a single clock of its tick. Register faults show on the next read, and a key or edge-detect fault shifts the following expiry by whole ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int CODE_W = 4;
  localparam logic [11:0] KICK_KEY = 12'hA57;

  // Returns {legal, tick count} for an interval code.
  function automatic logic [CNT_W:0] interval_lookup(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] t;
    logic ok;
    ok = 1'b1;
    case (code)
      4'd0:  t = 8'd1;
      4'd1:  t = 8'd2;
      4'd2:  t = 8'd4;
      4'd3:  t = 8'd6;
      4'd4:  t = 8'd8;
      4'd5:  t = 8'd10;
      4'd6:  t = 8'd12;
      4'd7:  t = 8'd16;
      4'd8:  t = 8'd20;
      4'd9:  t = 8'd24;
      4'd10: t = 8'd28;
      4'd11: t = 8'd32;
      default: begin t = '0; ok = 1'b0; end
    endcase
    return {ok, t};
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter bit KEYED  = 1'b1,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              load_o,
  output logic [CODE_W-1:0] code_o,
  output logic              en_o,
  output logic              rst_en_o
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = KEYED ? ADDR_W'('h10) : ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_MODE = KEYED ? ADDR_W'('h18) : ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_SA   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_SB   = ADDR_W'('h04);

  logic [DATA_W-1:0] mode_q, cfg_q, sa_q, sb_q, mode_eff;
  logic wr_ctrl, wr_mode, key_ok, kick, en_rise;

  assign wr_ctrl = we && (addr == OFS_CTRL);
  assign wr_mode = we && (addr == OFS_MODE);
  assign key_ok  = KEYED ? (wdata[12:1] == KICK_KEY) : 1'b1;
  assign kick    = wr_ctrl && wdata[0] && key_ok;
  assign en_rise = wr_mode && wdata[0] && !mode_q[0];
  assign load_o  = kick || en_rise;

  assign mode_eff = wr_mode ? wdata : mode_q;
  assign code_o   = KEYED ? mode_eff[7:4] : mode_eff[6:3];
  assign en_o     = mode_q[0];
  assign rst_en_o = KEYED ? cfg_q[0] : mode_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= wdata;

  generate
    if (KEYED) begin : g_store
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cfg_q <= '0; sa_q <= '0; sb_q <= '0;
        end else if (we) begin
          if (addr == OFS_CFG) cfg_q <= wdata;
          if (addr == OFS_SA)  sa_q  <= wdata;
          if (addr == OFS_SB)  sb_q  <= wdata;
        end

      a_r3_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CFG) |=> (cfg_q == $past(wdata)));
    end else begin : g_nostore
      assign cfg_q = '0;
      assign sa_q  = '0;
      assign sb_q  = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == OFS_MODE)              rdata = mode_q;
    else if (KEYED && addr == OFS_CFG) rdata = cfg_q;
    else if (KEYED && addr == OFS_SA)  rdata = sa_q;
    else if (KEYED && addr == OFS_SB)  rdata = sb_q;
  end

  // R6: a write while already enabled never reloads the counter
  a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && mode_q[0] && !wr_ctrl) |-> !load_o);
  // R2: writes to other offsets leave the mode word alone
  a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == OFS_MODE) |=> $stable(mode_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = wdog_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             load_legal,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && running && !load && (count <= ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0; running <= 1'b0;
    end else if (load) begin
      if (load_legal) count <= load_val;
      running <= 1'b1;
    end else if (tick && running) begin
      if (count <= ONE) begin
        count <= '0; running <= 1'b0;
      end else begin
        count <= count - ONE;
      end
    end

  a_r8_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == '0 && !running));
  a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !load && count > ONE) |=> (count == $past(count) - ONE));
  a_r7_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_legal) |=> (running && count == $past(count)));
  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_legal) |=> (running && count == $past(load_val)));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter bit KEYED  = 1'b1,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_req
);
  logic              load, en, rst_en, expire, running;
  logic [CODE_W-1:0] code;
  logic [CNT_W:0]    lk;
  logic [CNT_W-1:0]  count;

  wdog_regs #(.KEYED(KEYED), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .load_o(load), .code_o(code), .en_o(en), .rst_en_o(rst_en)
  );

  assign lk = interval_lookup(code);

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(half_tick), .load(load),
    .load_legal(lk[CNT_W]), .load_val(lk[CNT_W-1:0]),
    .expire(expire), .count(count), .running(running)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= expire && en && rst_en;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(en && rst_en && running));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> !sys_rst_req);
endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0;
  logic [7:0]  addr [2];
  logic        we   [2];
  logic [31:0] wd   [2];
  logic [31:0] rd   [2];
  logic        rq   [2];

  int nchk = 0, nfail = 0;
  int npulse [2];
  int mcnt [2];
  bit mrun [2];
  bit mreq [2];
  logic [31:0] mmode [2];
  logic [31:0] mcfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed #(.KEYED(1'b1), .ADDR_W(8)) u_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .bus_addr(addr[0]),
    .bus_we(we[0]), .bus_wdata(wd[0]), .bus_rdata(rd[0]), .sys_rst_req(rq[0]));

  wdog_keyed #(.KEYED(1'b0), .ADDR_W(8)) u_wdog_keyed_open (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .bus_addr(addr[1]),
    .bus_we(we[1]), .bus_wdata(wd[1]), .bus_rdata(rd[1]), .sys_rst_req(rq[1]));

  // Timeout table restated as arithmetic.
  function automatic int ticks_for(input int code);
    if (code == 0) return 1;
    if (code <= 6) return 2 * code;
    return 16 + 4 * (code - 7);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference, updated on every rising edge.
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      bit kd, ld, rsten;
      int ca, ma, code;
      logic [31:0] nm;
      if (!rst_n) begin
        mcnt[i] = 0; mrun[i] = 0; mreq[i] = 0; mmode[i] = '0;
        if (i == 0) mcfg = '0;
      end else begin
        kd = (i == 0);
        ca = kd ? 16 : 0;
        ma = kd ? 24 : 4;
        ld = 0;
        nm = mmode[i];
        if (we[i] && int'(addr[i]) == ca && wd[i][0] && (!kd || wd[i][12:1] == 12'hA57)) ld = 1;
        if (we[i] && int'(addr[i]) == ma) begin
          if (wd[i][0] && !mmode[i][0]) ld = 1;
          nm = wd[i];
        end
        rsten = kd ? mcfg[0] : mmode[i][1];
        mreq[i] = half_tick && mrun[i] && !ld && (mcnt[i] <= 1) && mmode[i][0] && rsten;
        if (ld) begin
          code = kd ? int'(nm[7:4]) : int'(nm[6:3]);
          if (code < 12) mcnt[i] = ticks_for(code);
          mrun[i] = 1;
        end else if (half_tick && mrun[i]) begin
          if (mcnt[i] <= 1) begin mcnt[i] = 0; mrun[i] = 0; end
          else mcnt[i] = mcnt[i] - 1;
        end
        mmode[i] = nm;
        if (kd && we[i] && addr[i] == 8'h14) mcfg = wd[i];
      end
    end
  end

  // Cycle compare of the reset request (R9, R8).
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        chk(rq[i] == mreq[i], "R9 per-cycle reset request", 32'(rq[i]), 32'(mreq[i]));
        if (rq[i]) npulse[i]++;
      end
    end
  end

  task automatic wr(input int i, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr[i] = a; we[i] = 1'b1; wd[i] = d;
    @(negedge clk); we[i] = 1'b0;
  endtask

  task automatic rdchk(input int i, input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr[i] = a;
    #1 chk(rd[i] == exp, tag, rd[i], exp);
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk); half_tick = 1'b1;
      @(negedge clk); half_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulses(input int i, input int n, input int exp, input string tag);
    int p0;
    p0 = npulse[i];
    tk(n);
    chk(npulse[i] - p0 == exp, tag, 32'(npulse[i] - p0), 32'(exp));
  endtask

  localparam logic [31:0] KICK_OK  = (32'hA57 << 1) | 32'h1;
  localparam logic [31:0] KICK_BAD = (32'hA56 << 1) | 32'h1;

  initial begin
    for (int i = 0; i < 2; i++) begin
      addr[i] = '0; we[i] = 1'b0; wd[i] = '0; npulse[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rdchk(0, 8'h00, 0, "R1 storage A after reset");
    rdchk(0, 8'h04, 0, "R1 storage B after reset");
    rdchk(0, 8'h10, 0, "R1 control after reset");
    rdchk(0, 8'h14, 0, "R1 config after reset");
    rdchk(0, 8'h18, 0, "R1 mode after reset");
    rdchk(1, 8'h04, 0, "R1 open mode after reset");
    chk(rq[0] == 1'b0, "R1 request low after reset", 32'(rq[0]), 0);
    // R3: storage words
    wr(0, 8'h00, 32'hDEADBEEF); rdchk(0, 8'h00, 32'hDEADBEEF, "R3 storage A");
    wr(0, 8'h04, 32'h12345678); rdchk(0, 8'h04, 32'h12345678, "R3 storage B");
    wr(0, 8'h14, 32'h00000001); rdchk(0, 8'h14, 32'h1, "R3 config");
    // R2: unmapped offsets
    wr(0, 8'h08, 32'hFFFF); rdchk(0, 8'h08, 0, "R2 unmapped read");
    wr(0, 8'h1C, 32'h21);   rdchk(0, 8'h1C, 0, "R2 unmapped 0x1C");
    rdchk(0, 8'h18, 0, "R2 unmapped write leaves mode");
    // R5: code 2 -> 4 ticks
    wr(0, 8'h18, 32'h21); rdchk(0, 8'h18, 32'h21, "R5 mode readback");
    pulses(0, 3, 0, "R5 no expiry before 4 ticks");
    pulses(0, 1, 1, "R9 expiry pulse at tick 4");
    pulses(0, 5, 0, "R8 stays stopped after expiry");
    // R4: key
    wr(0, 8'h10, KICK_OK); rdchk(0, 8'h10, 0, "R4 control reads zero");
    tk(2);
    wr(0, 8'h10, KICK_BAD);
    pulses(0, 2, 1, "R4 bad key ignored");
    wr(0, 8'h10, KICK_OK & ~32'h1);
    pulses(0, 6, 0, "R4 bit0 clear ignored");
    // R6: rewrite while enabled
    wr(0, 8'h10, KICK_OK); tk(2);
    wr(0, 8'h18, 32'hB1);
    pulses(0, 2, 1, "R6 rewrite does not reload");
    wr(0, 8'h10, KICK_OK);
    pulses(0, 31, 0, "R5 code 11 not before 32");
    pulses(0, 1, 1, "R5 code 11 at 32");
    // R7: illegal code keeps count
    wr(0, 8'h18, 32'h50); wr(0, 8'h18, 32'h51);
    tk(3);
    wr(0, 8'h18, 32'h50); wr(0, 8'h18, 32'hC1);
    pulses(0, 6, 0, "R7 kept count not yet out");
    pulses(0, 1, 1, "R7 kept count expires");
    wr(0, 8'h18, 32'hC0); wr(0, 8'hC1 - 8'hA9, 32'h0); wr(0, 8'h18, 32'hF1);
    pulses(0, 1, 1, "R7 zero count restarted");
    // R9 gating
    wr(0, 8'h14, 0); wr(0, 8'h18, 32'h00); wr(0, 8'h18, 32'h11);
    pulses(0, 3, 0, "R9 no request without reset-enable");
    wr(0, 8'h14, 1); wr(0, 8'h18, 32'h10); wr(0, 8'h10, KICK_OK);
    pulses(0, 3, 0, "R9 no request while disabled");
    // R10: keyless layout
    wr(1, 8'h04, 32'h0B); rdchk(1, 8'h04, 32'h0B, "R10 open mode readback");
    pulses(1, 1, 0, "R10 code 1 not after one tick");
    pulses(1, 1, 1, "R10 code 1 expires after two");
    wr(1, 8'h00, 32'h1);
    pulses(1, 2, 1, "R10 kick without key");
    rdchk(1, 8'h00, 0, "R10 control reads zero");
    wr(1, 8'h14, 32'hABCD); rdchk(1, 8'h14, 0, "R10 offset 0x14 unmapped");
    rdchk(1, 8'h18, 0, "R10 offset 0x18 unmapped");
    wr(1, 8'h04, 32'h09); wr(1, 8'h00, 32'h1);
    pulses(1, 3, 0, "R10 mode bit1 clear gates request");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule